// File: doc/BRIEF.md
# Match-Driven Timer Action Controller

This block is a timer with a prescaler and a set of match channels. A prescale counter runs from zero up to a programmable limit. Each time it wraps, the timer count steps up by one. Every match channel holds a compare value. When the timer count equals that value on the wrap cycle, the channel can do any mix of three things: set its sticky interrupt flag, send the timer count back to zero, or halt both counters and drop the run bit.

Software programs the block through a flat word-addressed register port. Writes take effect on the clock edge; reads are combinational from the address. The per-channel flags and their OR are brought out as ports, so an interrupt controller can take either form.

Top module: `match_timer_ctrl`

## Requirements
- R1: After reset every register reads 0 and irq is 0. Register words are: address 0 control (bit 0 run, bit 1 clear), 1 prescale limit, 2 match action word, 3 flags (bit i is channel i), 4 timer count (read only), 5 prescale count (read only), 8+i match value of channel i. Unmapped addresses read 0.
- R2: While run is 1 and clear is 0, the prescale count goes 0,1,..,limit and then back to 0. On that terminal cycle (the tick) the timer count steps by one, so the count rises by exactly 2 in any 8 cycles when the limit is 3.
- R3: The match action word gives channel i bit 3i for interrupt, bit 3i+1 for reset and bit 3i+2 for stop. Bits at 3*channels and above are dropped on write and read as 0 (all ones written reads back 0x1FFFFF with 7 channels).
- R4: On a tick where channel i's match value equals the timer count and its interrupt bit is set, flag i becomes 1 and stays 1. irq is 1 whenever any flag is 1.
- R5: Writing address 3 clears each flag whose data bit is 1. If the same flag is set by a match in that cycle, the set wins.
- R6: On a tick where a channel with reset enabled matches, the timer count becomes 0 instead of stepping. With match value M it therefore cycles 0..M and never exceeds M.
- R7: On a tick where a channel with stop enabled matches, the run bit is cleared (this wins over a write in the same cycle). The prescale count goes to 0, and the timer count keeps the match value and stays there.
- R8: When one matching channel has both reset and stop, the timer count becomes 0 and then holds with run cleared.
- R9: A channel whose three action bits are 0 has no effect when it matches: the count passes its value and its flag stays 0.
- R10: While the clear bit is 1, both counters are held at 0.
- R11: While run is 0, both counters keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register word address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr (combinational) |
| irqFlags | output | NUM_CH | Sticky per-channel interrupt flags |
| irq | output | 1 | OR of all flags |

## Verification
A wrong count or prescale state shows at the count read-back on the next cycle. It also shows up one tick later as a match event that comes early, late or not at all. A bad action decode shows as a flag, a zeroing or a dropped run bit on the wrong channel, all visible within one tick of the match. The bench runs a behavioural model beside the design and compares the read data, the flags and irq on every clock, so any such error is reported in the cycle it first reaches a port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef struct packed {
    logic runEn;       // counters may advance
    logic clrAll;      // hold both counters at zero
    logic zeroOnTick;  // a reset-enabled channel matches now
    logic holdOnTick;  // a stop-enabled channel matches now
  } tmr_strobe_t;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_PRE   = 1;
  localparam int ADDR_ACT   = 2;
  localparam int ADDR_FLAGS = 3;
  localparam int ADDR_TCNT  = 4;
  localparam int ADDR_PCNT  = 5;
  localparam int MATCH_BASE = 8;

  localparam int ACT_BITS   = 3;
  localparam int ACT_INT    = 0;
  localparam int ACT_RST    = 1;
  localparam int ACT_STOP   = 2;

endpackage

// File: rtl/tmr_match_chan.sv
module tmr_match_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] tcount,
  output logic [CNT_W-1:0] value,
  output logic             hit
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      value <= '0;
    end else if (wr) begin
      value <= wrData;
    end
  end

  assign hit = (value == tcount);

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tmr_strobe_t             strb,
  input  logic                    preWr,
  input  logic [NUM_CH-1:0]       matchWr,
  input  logic [CNT_W-1:0]        wrData,
  output logic                    tick,
  output logic [CNT_W-1:0]        tcount,
  output logic [CNT_W-1:0]        pcount,
  output logic [CNT_W-1:0]        preLimit,
  output logic [NUM_CH*CNT_W-1:0] matchVals,
  output logic [NUM_CH-1:0]       matchHit
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic preTerminal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preLimit <= '0;
    end else if (preWr) begin
      preLimit <= wrData;
    end
  end

  assign preTerminal = (pcount == preLimit);
  assign tick        = strb.runEn && !strb.clrAll && preTerminal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcount <= '0;
      tcount <= '0;
    end else if (strb.clrAll) begin
      pcount <= '0;
      tcount <= '0;
    end else if (tick) begin
      pcount <= '0;
      if (strb.zeroOnTick) begin
        tcount <= '0;
      end else if (!strb.holdOnTick) begin
        tcount <= tcount + CNT_ONE;
      end
    end else if (strb.runEn) begin
      pcount <= pcount + CNT_ONE;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    tmr_match_chan #(
      .CNT_W(CNT_W)
    ) u_chan (
      .clk   (clk),
      .rstN  (rstN),
      .wr    (matchWr[ch]),
      .wrData(wrData),
      .tcount(tcount),
      .value (matchVals[ch*CNT_W +: CNT_W]),
      .hit   (matchHit[ch])
    );
  end

endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busWe,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [DATA_W-1:0]       busWdata,
  output logic [DATA_W-1:0]       busRdata,
  input  logic                    tick,
  input  logic [NUM_CH-1:0]       matchHit,
  input  logic [CNT_W-1:0]        tcount,
  input  logic [CNT_W-1:0]        pcount,
  input  logic [CNT_W-1:0]        preLimit,
  input  logic [NUM_CH*CNT_W-1:0] matchVals,
  output tmr_strobe_t             strb,
  output logic                    preWr,
  output logic [NUM_CH-1:0]       matchWr,
  output logic [CNT_W-1:0]        wrData,
  output logic [NUM_CH*ACT_BITS-1:0] actWord,
  output logic [NUM_CH-1:0]       irqFlags,
  output logic                    irq
);

  localparam int ACT_W = NUM_CH * ACT_BITS;

  logic              runReg;
  logic              clrReg;
  logic [NUM_CH-1:0] intEn;
  logic [NUM_CH-1:0] rstEn;
  logic [NUM_CH-1:0] stopEn;
  logic [NUM_CH-1:0] setMask;
  logic [NUM_CH-1:0] clrMask;
  logic              ctrlWr;
  logic              actWr;
  logic              flagWr;
  logic              stopEvt;
  logic              unusedWdata;

  assign ctrlWr = busWe && (busAddr == ADDR_W'(ADDR_CTRL));
  assign preWr  = busWe && (busAddr == ADDR_W'(ADDR_PRE));
  assign actWr  = busWe && (busAddr == ADDR_W'(ADDR_ACT));
  assign flagWr = busWe && (busAddr == ADDR_W'(ADDR_FLAGS));
  assign wrData = busWdata[CNT_W-1:0];
  assign unusedWdata = ^busWdata;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dec
    assign matchWr[ch] = busWe && (busAddr == ADDR_W'(MATCH_BASE + ch));
    assign intEn[ch]   = actWord[ch*ACT_BITS + ACT_INT];
    assign rstEn[ch]   = actWord[ch*ACT_BITS + ACT_RST];
    assign stopEn[ch]  = actWord[ch*ACT_BITS + ACT_STOP];
  end

  // Match events count only on the prescale terminal cycle.
  assign setMask = tick ? (matchHit & intEn) : '0;
  assign clrMask = flagWr ? busWdata[NUM_CH-1:0] : '0;
  assign stopEvt = tick && |(matchHit & stopEn);

  assign strb.runEn      = runReg;
  assign strb.clrAll     = clrReg;
  assign strb.zeroOnTick = |(matchHit & rstEn);
  assign strb.holdOnTick = |(matchHit & stopEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg <= 1'b0;
      clrReg <= 1'b0;
    end else begin
      if (stopEvt) begin
        runReg <= 1'b0;
      end else if (ctrlWr) begin
        runReg <= busWdata[0];
      end
      if (ctrlWr) begin
        clrReg <= busWdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actWord <= '0;
    end else if (actWr) begin
      actWord <= busWdata[ACT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqFlags <= '0;
    end else begin
      irqFlags <= (irqFlags & ~clrMask) | setMask;
    end
  end

  assign irq = |irqFlags;

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(ADDR_CTRL)) begin
      busRdata = DATA_W'({clrReg, runReg});
    end else if (busAddr == ADDR_W'(ADDR_PRE)) begin
      busRdata = DATA_W'(preLimit);
    end else if (busAddr == ADDR_W'(ADDR_ACT)) begin
      busRdata = DATA_W'(actWord);
    end else if (busAddr == ADDR_W'(ADDR_FLAGS)) begin
      busRdata = DATA_W'(irqFlags);
    end else if (busAddr == ADDR_W'(ADDR_TCNT)) begin
      busRdata = DATA_W'(tcount);
    end else if (busAddr == ADDR_W'(ADDR_PCNT)) begin
      busRdata = DATA_W'(pcount);
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (busAddr == ADDR_W'(MATCH_BASE + ch)) begin
          busRdata = DATA_W'(matchVals[ch*CNT_W +: CNT_W]);
        end
      end
    end
  end

endmodule

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] irqFlags,
  output logic              irq
);

  localparam int ACT_W = NUM_CH * ACT_BITS;

  tmr_strobe_t              strb;
  logic                     tick;
  logic                     preWr;
  logic [NUM_CH-1:0]        matchWr;
  logic [CNT_W-1:0]         wrData;
  logic [CNT_W-1:0]         tcount;
  logic [CNT_W-1:0]         pcount;
  logic [CNT_W-1:0]         preLimit;
  logic [NUM_CH*CNT_W-1:0]  matchVals;
  logic [NUM_CH-1:0]        matchHit;
  logic [ACT_W-1:0]         actWord;

  tmr_control #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .tick     (tick),
    .matchHit (matchHit),
    .tcount   (tcount),
    .pcount   (pcount),
    .preLimit (preLimit),
    .matchVals(matchVals),
    .strb     (strb),
    .preWr    (preWr),
    .matchWr  (matchWr),
    .wrData   (wrData),
    .actWord  (actWord),
    .irqFlags (irqFlags),
    .irq      (irq)
  );

  tmr_datapath #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .preWr    (preWr),
    .matchWr  (matchWr),
    .wrData   (wrData),
    .tick     (tick),
    .tcount   (tcount),
    .pcount   (pcount),
    .preLimit (preLimit),
    .matchVals(matchVals),
    .matchHit (matchHit)
  );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input tmr_strobe_t                strb,
  input logic                       tick,
  input logic [NUM_CH-1:0]          matchHit,
  input logic [NUM_CH*ACT_BITS-1:0] actWord,
  input logic [CNT_W-1:0]           tcount,
  input logic [CNT_W-1:0]           pcount,
  input logic [NUM_CH-1:0]          irqFlags,
  input logic                       busWe,
  input logic [ADDR_W-1:0]          busAddr
);

  logic [NUM_CH-1:0] rstSel;
  logic [NUM_CH-1:0] stopSel;
  logic              anyRst;
  logic              anyStop;
  logic              flagClrWr;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
    assign rstSel[ch]  = actWord[ch*ACT_BITS + ACT_RST];
    assign stopSel[ch] = actWord[ch*ACT_BITS + ACT_STOP];
  end

  assign anyRst    = tick && |(matchHit & rstSel);
  assign anyStop   = tick && |(matchHit & stopSel);
  assign flagClrWr = busWe && (busAddr == ADDR_W'(ADDR_FLAGS));

  // R2: a plain tick steps the count by one
  a_r2_tick_steps: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !anyRst && !anyStop) |=> (tcount == CNT_W'($past(tcount) + 1'b1)));

  // R4: flags are sticky without a clearing write
  a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (|irqFlags && !flagClrWr) |=> ((irqFlags & $past(irqFlags)) == $past(irqFlags)));

  // R6: reset-enabled match zeroes the count
  a_r6_match_zero: assert property (@(posedge clk) disable iff (!rstN)
    anyRst |=> (tcount == '0));

  // R7: stop-enabled match drops the run bit
  a_r7_stop_clears_run: assert property (@(posedge clk) disable iff (!rstN)
    anyStop |=> !strb.runEn);

  // R7: stop without reset keeps the matched count
  a_r7_stop_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (anyStop && !anyRst) |=> $stable(tcount) && (pcount == '0));

  // R10: clear holds both counters at zero
  a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (tcount == '0) && (pcount == '0));

  // R11: idle counters keep their value
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.runEn && !strb.clrAll) |=> $stable(tcount) && $stable(pcount));

endmodule

bind match_timer_ctrl tmr_checker #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .strb    (strb),
  .tick    (tick),
  .matchHit(matchHit),
  .actWord (actWord),
  .tcount  (tcount),
  .pcount  (pcount),
  .irqFlags(irqFlags),
  .busWe   (busWe),
  .busAddr (busAddr)
);

// File: tb/match_timer_ctrl_bench.sv
module match_timer_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [6:0]  irqFlags;
  logic        irq;

  int    total = 0;
  int    bad = 0;
  bit    started = 1'b0;
  bit    done = 1'b0;
  string curReq = "R1";

  // behavioural reference state
  logic [31:0] mPc, mTc, mPre, mAct;
  logic        mRun, mClr;
  logic [6:0]  mFlags;
  logic [31:0] mMatch [7];

  always #10 clk = ~clk;

  match_timer_ctrl u_match_timer_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqFlags(irqFlags), .irq(irq)
  );

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(input logic [3:0] a);
    case (a)
      4'd0: return {30'd0, mClr, mRun};
      4'd1: return mPre;
      4'd2: return mAct;
      4'd3: return {25'd0, mFlags};
      4'd4: return mTc;
      4'd5: return mPc;
      default: begin
        if (a >= 4'd8 && a <= 4'd14) return mMatch[a - 4'd8];
        return 32'd0;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPc = 0; mTc = 0; mPre = 0; mAct = 0; mRun = 0; mClr = 0; mFlags = 0;
      for (int i = 0; i < 7; i++) mMatch[i] = 0;
    end else begin
      bit tk, z, s;
      logic [6:0] setm;
      tk = mRun && !mClr && (mPc == mPre);
      z = 0; s = 0; setm = 0;
      for (int i = 0; i < 7; i++) begin
        if (tk && mTc == mMatch[i]) begin
          if (mAct[3*i])   setm[i] = 1'b1;
          if (mAct[3*i+1]) z = 1'b1;
          if (mAct[3*i+2]) s = 1'b1;
        end
      end
      if (mClr) begin
        mPc = 0; mTc = 0;
      end else if (tk) begin
        mPc = 0;
        if (z) mTc = 0;
        else if (!s) mTc = mTc + 1;
      end else if (mRun) begin
        mPc = mPc + 1;
      end
      if (busWe && busAddr == 4'd3) mFlags = mFlags & ~busWdata[6:0];
      mFlags = mFlags | setm;
      if (busWe) begin
        case (busAddr)
          4'd0: begin mRun = busWdata[0]; mClr = busWdata[1]; end
          4'd1: mPre = busWdata;
          4'd2: mAct = busWdata & 32'h001F_FFFF;
          default: if (busAddr >= 4'd8 && busAddr <= 4'd14)
                     mMatch[busAddr - 4'd8] = busWdata;
        endcase
      end
      if (s) mRun = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checkEq(curReq, "model rdata", busRdata, mRead(busAddr));
      checkEq(curReq, "model flags", {25'd0, irqFlags}, {25'd0, mFlags});
      checkEq(curReq, "model irq", {31'd0, irq}, {31'd0, |mFlags});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    #1 busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    #1 busWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    #1 busWe = 1'b0; busAddr = a;
    @(negedge clk);
    d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, mx, mn;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    started = 1'b1;

    // R1 reset state
    curReq = "R1";
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      checkEq("R1", "reset read", v, 32'd0);
    end
    checkEq("R1", "reset irq", {31'd0, irq}, 32'd0);

    // R3 reserved bits dropped
    curReq = "R3";
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, v);
    checkEq("R3", "action word readback", v, 32'h001F_FFFF);
    wr(4'd2, 32'd0);

    // R2 prescale rate
    curReq = "R2";
    wr(4'd1, 32'd3);
    wr(4'd0, 32'd1);
    idle(5);
    rd(4'd4, v);
    idle(7);
    rd(4'd4, v2);
    checkEq("R2", "count step over 8 cycles", v2 - v, 32'd2);
    mx = 0; mn = 32'hFFFF_FFFF;
    for (int k = 0; k < 8; k++) begin
      rd(4'd5, v);
      if (v > mx) mx = v;
      if (v < mn) mn = v;
    end
    checkEq("R2", "prescale max", mx, 32'd3);
    checkEq("R2", "prescale min", mn, 32'd0);

    // R11 idle hold
    curReq = "R11";
    wr(4'd0, 32'd0);
    rd(4'd4, v);
    idle(6);
    rd(4'd4, v2);
    checkEq("R11", "count held while idle", v2, v);

    // R10 clear
    curReq = "R10";
    wr(4'd0, 32'd2);
    idle(2);
    rd(4'd4, v);
    checkEq("R10", "count under clear", v, 32'd0);
    rd(4'd5, v);
    checkEq("R10", "prescale under clear", v, 32'd0);

    // R4 / R9 interrupt and inert channel
    curReq = "R4";
    wr(4'd1, 32'd0);
    wr(4'd8, 32'd10);
    wr(4'd9, 32'd4);
    wr(4'd2, 32'h0000_0001);
    wr(4'd0, 32'd1);
    idle(30);
    rd(4'd3, v);
    checkEq("R4", "flags after ch0 match", v, 32'h1);
    checkEq("R4", "irq after ch0 match", {31'd0, irq}, 32'd1);
    curReq = "R9";
    rd(4'd4, v);
    checkEq("R9", "count passed inert match", {31'd0, v > 32'd12}, 32'd1);
    rd(4'd0, v);
    checkEq("R9", "run still set", v, 32'd1);

    // R5 write-one clear
    curReq = "R5";
    wr(4'd3, 32'h1);
    rd(4'd3, v);
    checkEq("R5", "flags after clear", v, 32'd0);
    checkEq("R5", "irq after clear", {31'd0, irq}, 32'd0);

    // R6 reset on match (ch2 reset = bit 7)
    curReq = "R6";
    wr(4'd0, 32'd0);
    wr(4'd10, 32'd5);
    wr(4'd2, 32'h0000_0080);
    wr(4'd0, 32'd2);
    wr(4'd0, 32'd1);
    mx = 0; mn = 32'hFFFF_FFFF;
    for (int k = 0; k < 20; k++) begin
      rd(4'd4, v);
      if (v > mx) mx = v;
      if (v < mn) mn = v;
    end
    checkEq("R6", "count maximum", mx, 32'd5);
    checkEq("R6", "count minimum", mn, 32'd0);

    // R7 stop on match (ch4 stop = bit 14)
    curReq = "R7";
    wr(4'd0, 32'd0);
    wr(4'd12, 32'd7);
    wr(4'd1, 32'd2);
    wr(4'd2, 32'h0000_4000);
    wr(4'd0, 32'd2);
    wr(4'd0, 32'd1);
    idle(60);
    rd(4'd0, v);
    checkEq("R7", "run cleared", v, 32'd0);
    rd(4'd4, v);
    checkEq("R7", "count holds match", v, 32'd7);
    rd(4'd5, v);
    checkEq("R7", "prescale zero", v, 32'd0);
    idle(10);
    rd(4'd4, v);
    checkEq("R7", "count still held", v, 32'd7);

    // R8 reset+stop+int on ch6 (bits 18,19,20)
    curReq = "R8";
    wr(4'd14, 32'd9);
    wr(4'd1, 32'd1);
    wr(4'd2, 32'h001C_0000);
    wr(4'd0, 32'd2);
    wr(4'd0, 32'd1);
    idle(60);
    rd(4'd0, v);
    checkEq("R8", "run cleared", v, 32'd0);
    rd(4'd4, v);
    checkEq("R8", "count zero and held", v, 32'd0);
    rd(4'd3, v);
    checkEq("R8", "ch6 flag", v, 32'h40);

    // R5 set wins over clear
    curReq = "R5";
    wr(4'd3, 32'h7F);
    wr(4'd8, 32'd0);
    wr(4'd1, 32'd0);
    wr(4'd2, 32'h0000_0003);
    wr(4'd0, 32'd2);
    wr(4'd0, 32'd1);
    idle(4);
    wr(4'd3, 32'h1);
    rd(4'd3, v);
    checkEq("R5", "set wins over clear", v, 32'h1);
    wr(4'd0, 32'd0);
    wr(4'd3, 32'h1);
    rd(4'd3, v);
    checkEq("R5", "clear when idle", v, 32'd0);

    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule